// File: doc/BRIEF.md
# PS/2 Keyboard Receive Controller

This block sits between a PS/2 keyboard cable and a host processor. It samples the keyboard's clock and data lines and assembles each 11-bit serial character into a byte. Every byte is handed to the host unchanged. The bytes are raw scan codes, and a single keystroke can produce several of them, with different codes for pressing a key and for releasing it. Frames with a bad parity bit or a bad stop bit are thrown away and reported as errors.

The host reaches the block through two fixed 8-bit I/O ports. A read at 0x60 returns the received byte. A read at 0x64 returns a status byte, and a write to 0x64 carries a command. An interrupt line, meant for input 1 of the system interrupt controller, is high while a byte is waiting. Reading the data port drops it. Sending to the keyboard, pointing devices and a second channel are not part of this block.

Top module: `kbd_port_ctrl`

## Requirements
- R1: A frame is a start bit of 0, then eight data bits with the least significant bit first, then an odd-parity bit, then a stop bit of 1. Each bit is sampled on a falling edge of the keyboard clock. Both lines pass through two synchroniser flops. A valid frame makes its byte readable at port 0x60, and consecutive frames deliver their bytes in the order they arrived.
- R2: Status bit 0 (buffer full) and irq_o go high on the fourth system clock edge after the keyboard clock falls for the stop bit. Both clear on the clock edge that completes a read of port 0x60. irq_o always equals status bit 0.
- R3: A frame with wrong parity (data plus parity bit not holding an odd count of ones) or a stop bit of 0 is discarded. It sets status bit 7 and leaves the data buffer and status bit 0 unchanged.
- R4: A valid byte that arrives while status bit 0 is set is dropped. It sets status bit 5, and the buffer keeps the old byte.
- R5: When a read of port 0x60 falls in the same cycle as a byte load, the read returns the old byte and the new byte is stored. Status bit 0 stays set and status bit 5 is not set.
- R6: A read of port 0x64 returns status bits 5 and 7 as they were and then clears them. If an error occurs in the same cycle as that read, its bit stays set.
- R7: If TIMEOUT_CYC system clocks pass inside a frame with no keyboard clock falling edge, the receiver returns to waiting for a start bit.
- R8: While the receiver is idle, a keyboard clock falling edge with data at 1 is not taken as a start bit.
- R9: Writing 0xAD to port 0x64 inhibits reception and sets status bit 4. Frames completed while inhibited are discarded silently. Writing 0xAE to port 0x64 re-enables reception. Any other command value, and any write to port 0x60, has no effect.
- R10: After reset, status reads 0x00 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kb_clk_i | input | 1 | Keyboard clock line, asynchronous |
| kb_dat_i | input | 1 | Keyboard data line, asynchronous |
| io_addr | input | 8 | Host I/O port address |
| io_rd | input | 1 | Host read strobe, one cycle |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data for the addressed port, combinational |
| irq_o | output | 1 | Interrupt request, high while a byte waits |

## Verification
Two pairs of events can land in the same clock edge. The first pair is a byte load and a host read of the data port. The second pair is an error from the framer and a host read of the status port. The bench provokes each collision by counting the stated four-cycle latency from the stop-bit clock fall and placing the host read in exactly that cycle. For the data-port collision it then checks that the read returned the old byte, that the new byte is stored, and that no overrun was flagged. For the status-port collision it checks that the status read missed the error and that a second status read shows it set.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

  localparam logic [7:0] PORT_DATA = 8'h60;
  localparam logic [7:0] PORT_CTRL = 8'h64;

  localparam logic [7:0] CMD_INHIBIT = 8'hAD;
  localparam logic [7:0] CMD_RESUME  = 8'hAE;

  localparam int FRAME_BITS = 11;

  typedef struct packed {
    logic       perr;
    logic       rsv6;
    logic       ovr;
    logic       inh;
    logic [2:0] rsv;
    logic       obf;
  } kbd_status_t;

  // odd parity: data plus parity bit carry an odd number of ones
  function automatic logic odd_parity_ok(input logic [7:0] d, input logic p);
    return ^{d, p};
  endfunction

  function automatic logic frame_valid(input logic [7:0] d, input logic p,
                                       input logic stop);
    return odd_parity_ok(d, p) & stop;
  endfunction

  // set has priority over clear
  function automatic logic next_flag(input logic set, input logic clr,
                                     input logic cur);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [7:0] pack_status(input logic perr, input logic ovr,
                                             input logic inh, input logic obf);
    kbd_status_t s;
    s.perr = perr;
    s.rsv6 = 1'b0;
    s.ovr  = ovr;
    s.inh  = inh;
    s.rsv  = 3'b000;
    s.obf  = obf;
    return s;
  endfunction

endpackage

// File: rtl/kbd_sync_edge.sv
module kbd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kb_clk_i,
  input  logic kb_dat_i,
  output logic fall_o,
  output logic dat_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] lines_in;
  logic [NLINES-1:0] lines_sync;
  logic              clk_prev;

  assign lines_in = {kb_dat_i, kb_clk_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], lines_in[g]};
    end
    assign lines_sync[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b1;
    else        clk_prev <= lines_sync[0];
  end

  assign fall_o = clk_prev & ~lines_sync[0];
  assign dat_o  = lines_sync[1];

endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_i,
  input  logic       dat_i,
  output logic       ok_o,
  output logic       bad_o,
  output logic [7:0] byte_o,
  output logic [3:0] idx_o,
  output logic       tmo_o
);
  localparam int          TW       = $clog2(TIMEOUT_CYC + 1);
  localparam logic [3:0]  STOP_IDX = 4'(FRAME_BITS - 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT_CYC - 1);

  logic [3:0]    idx;
  logic [8:0]    shreg;
  logic [TW-1:0] cnt;

  assign idx_o = idx;
  assign tmo_o = (idx != 4'd0) && !fall_i && (cnt == TMO_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= 4'd0;
      shreg  <= '0;
      cnt    <= '0;
      ok_o   <= 1'b0;
      bad_o  <= 1'b0;
      byte_o <= 8'h00;
    end else begin
      ok_o  <= 1'b0;
      bad_o <= 1'b0;
      if (fall_i) begin
        cnt <= '0;
        if (idx == 4'd0) begin
          if (!dat_i) idx <= 4'd1;
        end else if (idx < STOP_IDX) begin
          shreg <= {dat_i, shreg[8:1]};
          idx   <= idx + 4'd1;
        end else begin
          idx    <= 4'd0;
          byte_o <= shreg[7:0];
          if (frame_valid(shreg[7:0], shreg[8], dat_i)) ok_o  <= 1'b1;
          else                                          bad_o <= 1'b1;
        end
      end else if (idx != 4'd0) begin
        if (tmo_o) begin
          idx <= 4'd0;
          cnt <= '0;
        end else begin
          cnt <= cnt + TW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/kbd_host_regs.sv
module kbd_host_regs
  import kbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ok_i,
  input  logic       bad_i,
  input  logic [7:0] byte_i,
  input  logic [7:0] io_addr,
  input  logic       io_rd,
  input  logic       io_wr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic       irq_o,
  output logic       load_o,
  output logic       drop_o,
  output logic       data_rd_o,
  output logic       stat_rd_o,
  output logic [7:0] buf_o,
  output logic [7:0] status_o
);
  logic obf, ovr, perr, inh;
  logic [7:0] data_buf;
  logic cmd_wr, accept, bad_ev;

  assign data_rd_o = io_rd && (io_addr == PORT_DATA);
  assign stat_rd_o = io_rd && (io_addr == PORT_CTRL);
  assign cmd_wr    = io_wr && (io_addr == PORT_CTRL);

  assign accept = ok_i && !inh;
  assign bad_ev = bad_i && !inh;
  assign load_o = accept && (!obf || data_rd_o);
  assign drop_o = accept && obf && !data_rd_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf      <= 1'b0;
      ovr      <= 1'b0;
      perr     <= 1'b0;
      inh      <= 1'b0;
      data_buf <= 8'h00;
    end else begin
      obf  <= next_flag(load_o, data_rd_o, obf);
      ovr  <= next_flag(drop_o, stat_rd_o, ovr);
      perr <= next_flag(bad_ev, stat_rd_o, perr);
      inh  <= next_flag(cmd_wr && io_wdata == CMD_INHIBIT,
                        cmd_wr && io_wdata == CMD_RESUME, inh);
      if (load_o) data_buf <= byte_i;
    end
  end

  assign status_o = pack_status(perr, ovr, inh, obf);
  assign buf_o    = data_buf;
  assign irq_o    = obf;

  always_comb begin
    unique case (io_addr)
      PORT_DATA: io_rdata = data_buf;
      PORT_CTRL: io_rdata = status_o;
      default:   io_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/kbd_port_ctrl.sv
module kbd_port_ctrl #(
  parameter int TIMEOUT_CYC = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kb_clk_i,
  input  logic       kb_dat_i,
  input  logic [7:0] io_addr,
  input  logic       io_rd,
  input  logic       io_wr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic       irq_o
);
  // internal events, named for the checker
  logic       kb_fall;
  logic       kb_dat;
  logic       frame_ok;
  logic       frame_bad;
  logic [7:0] rx_byte;
  logic [3:0] bit_idx;
  logic       tmo_ev;
  logic       load_ev;
  logic       drop_ev;
  logic       data_rd;
  logic       stat_rd;
  logic [7:0] data_buf;
  logic [7:0] status;

  kbd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .kb_clk_i (kb_clk_i),
    .kb_dat_i (kb_dat_i),
    .fall_o   (kb_fall),
    .dat_o    (kb_dat)
  );

  kbd_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .fall_i (kb_fall),
    .dat_i  (kb_dat),
    .ok_o   (frame_ok),
    .bad_o  (frame_bad),
    .byte_o (rx_byte),
    .idx_o  (bit_idx),
    .tmo_o  (tmo_ev)
  );

  kbd_host_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ok_i      (frame_ok),
    .bad_i     (frame_bad),
    .byte_i    (rx_byte),
    .io_addr   (io_addr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .irq_o     (irq_o),
    .load_o    (load_ev),
    .drop_o    (drop_ev),
    .data_rd_o (data_rd),
    .stat_rd_o (stat_rd),
    .buf_o     (data_buf),
    .status_o  (status)
  );

endmodule

// File: rtl/kbd_port_ctrl_chk.sv
module kbd_port_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_ok,
  input logic       frame_bad,
  input logic [7:0] rx_byte,
  input logic [3:0] bit_idx,
  input logic       tmo_ev,
  input logic       drop_ev,
  input logic       data_rd,
  input logic       stat_rd,
  input logic [7:0] data_buf,
  input logic [7:0] status,
  input logic       irq_o
);

  p_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && frame_bad));

  p_accept_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && !status[4] && !status[0]) |=>
      (irq_o && status[0] && data_buf == $past(rx_byte)));

  p_read_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !frame_ok) |=> !irq_o);

  p_bad_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_bad && !status[4]) |=> (status[7] && $stable(data_buf)));

  p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && !status[4] && status[0] && !data_rd) |=>
      (status[5] && $stable(data_buf)));

  p_drop_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |-> (status[0] && frame_ok));

  p_collide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && !status[4] && status[0] && data_rd) |=>
      (status[0] && data_buf == $past(rx_byte) && status[5] == $past(status[5])));

  p_status_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !frame_ok && !frame_bad) |=> (!status[7] && !status[5]));

  p_timeout_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_ev |=> (bit_idx == 4'd0));

  p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= 4'd10);

  p_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && (frame_ok || frame_bad)) |=> $stable(data_buf));

endmodule

bind kbd_port_ctrl kbd_port_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_ok  (frame_ok),
  .frame_bad (frame_bad),
  .rx_byte   (rx_byte),
  .bit_idx   (bit_idx),
  .tmo_ev    (tmo_ev),
  .drop_ev   (drop_ev),
  .data_rd   (data_rd),
  .stat_rd   (stat_rd),
  .data_buf  (data_buf),
  .status    (status),
  .irq_o     (irq_o)
);

// File: tb/sim_kbd_port_ctrl.sv
module sim_kbd_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int TMO        = 64;
  localparam logic [7:0] A_DATA = 8'h60;
  localparam logic [7:0] A_CTRL = 8'h64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kb_clk = 1'b1;
  logic       kb_dat = 1'b1;
  logic [7:0] io_addr = 8'h00;
  logic       io_rd = 1'b0;
  logic       io_wr = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic       irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit mon_en = 1'b0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_port_ctrl #(.TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk), .kb_dat_i(kb_dat),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a;
    io_rd   = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr  = a;
    io_wdata = d;
    io_wr    = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic kb_bit(input logic b);
    @(negedge clk);
    kb_dat = b;
    repeat (HALF) @(negedge clk);
    kb_clk = 1'b0;
    repeat (HALF) @(negedge clk);
    kb_clk = 1'b1;
  endtask

  task automatic frame_head(input logic [7:0] b, input bit bad_par);
    kb_bit(1'b0);
    for (int i = 0; i < 8; i++) kb_bit(b[i]);
    kb_bit(~(^b) ^ bad_par);
  endtask

  // ends in the negedge where the keyboard clock is driven low
  task automatic stop_fall(input bit bad_stop);
    @(negedge clk);
    kb_dat = ~bad_stop;
    repeat (HALF) @(negedge clk);
    kb_clk = 1'b0;
  endtask

  task automatic stop_rise();
    repeat (HALF) @(negedge clk);
    kb_clk = 1'b1;
    kb_dat = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit bad_par, input bit bad_stop);
    frame_head(b, bad_par);
    stop_fall(bad_stop);
    stop_rise();
  endtask

  task automatic send_exp(input logic [7:0] b);
    exp_q.push_back(b);
    send(b, 1'b0, 1'b0);
  endtask

  // scoreboard monitor
  always begin
    logic [7:0] got;
    @(negedge clk);
    if (mon_en && irq_o) begin
      bus_read(A_DATA, got);
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected byte", got, 8'h00);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(got == e, "R1 scoreboard byte", got, e);
      end
    end
  end

  task automatic mon_off();
    mon_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 8'h00, 8'h00);
    report();
  end

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10 reset state
    chk(irq_o == 1'b0, "R10 irq after reset", {7'd0, irq_o}, 8'h00);
    bus_read(A_CTRL, d);
    chk(d == 8'h00, "R10 status after reset", d, 8'h00);

    // R1 scoreboard: single and multibyte sequences, parity corner bytes
    mon_en = 1'b1;
    send_exp(8'h1C);
    send_exp(8'hE0);
    send_exp(8'hF0);
    send_exp(8'h1C);
    send_exp(8'h00);
    send_exp(8'hFF);
    send_exp(8'h81);
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all bytes delivered", 8'(exp_q.size()), 8'h00);
    mon_off();

    // R2 latency of buffer-full and irq
    frame_head(8'h2A, 1'b0);
    stop_fall(1'b0);
    repeat (3) @(negedge clk);
    chk(irq_o == 1'b0, "R2 irq before fourth edge", {7'd0, irq_o}, 8'h00);
    @(negedge clk);
    chk(irq_o == 1'b1, "R2 irq at fourth edge", {7'd0, irq_o}, 8'h01);
    stop_rise();
    bus_read(A_CTRL, d);
    chk(d == 8'h01, "R2 status full", d, 8'h01);

    // R4 overrun: buffer still holds 2A
    send(8'h55, 1'b0, 1'b0);
    bus_read(A_CTRL, d);
    chk(d == 8'h21, "R4 overrun status", d, 8'h21);
    bus_read(A_CTRL, d);
    chk(d == 8'h01, "R6 overrun cleared by status read", d, 8'h01);
    bus_read(A_DATA, d);
    chk(d == 8'h2A, "R4 old byte kept", d, 8'h2A);
    @(negedge clk);
    chk(irq_o == 1'b0, "R2 irq cleared by data read", {7'd0, irq_o}, 8'h00);

    // R3 parity error and stop error
    send(8'h33, 1'b1, 1'b0);
    bus_read(A_CTRL, d);
    chk(d == 8'h80, "R3 parity error status", d, 8'h80);
    chk(irq_o == 1'b0, "R3 no irq on bad parity", {7'd0, irq_o}, 8'h00);
    bus_read(A_CTRL, d);
    chk(d == 8'h00, "R6 parity flag cleared", d, 8'h00);
    send(8'h44, 1'b0, 1'b1);
    bus_read(A_CTRL, d);
    chk(d == 8'h80, "R3 stop error status", d, 8'h80);
    bus_read(A_DATA, d);
    chk(d == 8'h2A, "R3 buffer unchanged by bad frame", d, 8'h2A);
    bus_read(A_CTRL, d);

    // R5 data read in the load cycle
    send(8'h11, 1'b0, 1'b0);
    frame_head(8'h22, 1'b0);
    stop_fall(1'b0);
    repeat (2) @(negedge clk);
    bus_read(A_DATA, d);
    chk(d == 8'h11, "R5 collide read returns old byte", d, 8'h11);
    stop_rise();
    bus_read(A_CTRL, d);
    chk(d == 8'h01, "R5 full and no overrun", d, 8'h01);
    bus_read(A_DATA, d);
    chk(d == 8'h22, "R5 new byte stored", d, 8'h22);

    // R6 status read in the cycle a parity error lands
    frame_head(8'h3C, 1'b1);
    stop_fall(1'b0);
    repeat (2) @(negedge clk);
    bus_read(A_CTRL, d);
    chk(d == 8'h00, "R6 collide status read", d, 8'h00);
    stop_rise();
    bus_read(A_CTRL, d);
    chk(d == 8'h80, "R6 error kept after same-cycle read", d, 8'h80);

    // R7 timeout in mid-frame
    kb_bit(1'b0);
    kb_bit(1'b1);
    kb_bit(1'b0);
    kb_bit(1'b1);
    repeat (TMO + 20) @(negedge clk);
    send(8'h5A, 1'b0, 1'b0);
    bus_read(A_CTRL, d);
    chk(d == 8'h01, "R7 clean frame after timeout", d, 8'h01);
    bus_read(A_DATA, d);
    chk(d == 8'h5A, "R7 byte after timeout", d, 8'h5A);

    // R8 clock fall with data high while idle
    kb_bit(1'b1);
    send(8'h6B, 1'b0, 1'b0);
    bus_read(A_DATA, d);
    chk(d == 8'h6B, "R8 idle high bit ignored", d, 8'h6B);
    bus_read(A_CTRL, d);
    chk(d == 8'h00, "R8 status clean", d, 8'h00);

    // R9 inhibit command
    bus_write(A_CTRL, 8'hAD);
    bus_read(A_CTRL, d);
    chk(d == 8'h10, "R9 inhibit flag", d, 8'h10);
    send(8'h77, 1'b0, 1'b0);
    send(8'h78, 1'b1, 1'b0);
    bus_read(A_CTRL, d);
    chk(d == 8'h10, "R9 frames discarded when inhibited", d, 8'h10);
    chk(irq_o == 1'b0, "R9 no irq when inhibited", {7'd0, irq_o}, 8'h00);
    bus_write(A_CTRL, 8'h12);
    bus_write(A_DATA, 8'hAE);
    bus_read(A_CTRL, d);
    chk(d == 8'h10, "R9 other writes no effect", d, 8'h10);
    bus_write(A_CTRL, 8'hAE);
    bus_read(A_CTRL, d);
    chk(d == 8'h00, "R9 resume clears inhibit", d, 8'h00);
    send(8'h79, 1'b0, 1'b0);
    bus_read(A_DATA, d);
    chk(d == 8'h79, "R9 reception resumed", d, 8'h79);

    repeat (4) @(negedge clk);
    report();
  end

endmodule